// File: doc/BRIEF.md
# Belt Operand Mapping Unit

This block keeps the ordering of a belt of logical operand positions and maps each belt number to the physical location tag of the storage that holds the value, such as a producer's output latch. It stores and moves no operand data. A drop writes only a location tag at the front of the belt, and the older entries slide one place back. Several producer ports may drop in the same cycle.

A taken branch supplies a congruence list of belt numbers. The belt is rebuilt so that it holds exactly those entries, in the listed order, with no extra cycle. Every dropped operand carries a timestamp, which is its index in the endless sequence of drops modulo twice the belt size. When a value has to leave its producer's output storage, a relocation request points its belt position at the new location. Entries that are pushed off the back of the belt come out on release lanes in the same cycle, so their storage can be reclaimed.

Top module: `beltMap`

## Requirements
- R1: After reset the belt is empty: every read returns rdValid=0, rdLoc=0 and rdStamp=0.
- R2: A single drop puts its location at belt position 0. Every older entry moves from position p to p+1. The change is visible on the read ports in the cycle after the drop edge.
- R3: When several ports drop in one cycle, the active ports fill positions 0, 1, 2, ... in ascending port number. The lowest-numbered active port becomes position 0.
- R4: Each drop is stamped with its index in the running drop sequence, modulo 2*BELT_SIZE, starting at 0 after reset. Within one cycle the higher-numbered active ports take the earlier indices. A stamp travels with its entry through shifts, reorders and relocations.
- R5: The valid count saturates at BELT_SIZE. When d drops push entries past position BELT_SIZE-1, release lane k (k < d) reports, in the same cycle, the location of the entry leaving from position BELT_SIZE-1-k, if that position was occupied. Otherwise the lane is low and its location is 0.
- R6: A read at a belt number greater than or equal to the valid count returns rdValid=0, rdLoc=0 and rdStamp=0.
- R7: When brTaken is high, the next belt holds, at position i, the entry found at belt number brList[i], for i < brCount. The valid count becomes brCount, clamped to BELT_SIZE.
- R8: A branch and drops in the same cycle are applied in sequence. The reorder comes first, and the drops are then pushed onto the front of the reordered belt.
- R9: A relocation replaces the location tag at belt number relocPos and leaves its stamp and the belt order unchanged. It is applied before any reorder or drop in the same cycle. A relocation at a belt number at or beyond the valid count has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dropValid | input | DROP_PORTS | One drop request per producer port |
| dropLoc | input | DROP_PORTS x LOC_W | Location tag of each port's new result |
| brTaken | input | 1 | Apply the congruence list this cycle |
| brCount | input | POS_W+1 | Number of entries in the congruence list |
| brList | input | BELT_SIZE x POS_W | Belt numbers forming the new belt, front first |
| relocValid | input | 1 | Relocation request |
| relocPos | input | POS_W | Belt number whose value was moved |
| relocLoc | input | LOC_W | New location of that value |
| rdPos | input | RD_PORTS x POS_W | Belt number looked up by each read port |
| rdValid | output | RD_PORTS | The looked-up position holds a live operand |
| rdLoc | output | RD_PORTS x LOC_W | Location tag at that position |
| rdStamp | output | RD_PORTS x STAMP_W | Drop timestamp at that position |
| relValid | output | DROP_PORTS | A location falls off the belt on this lane |
| relLoc | output | DROP_PORTS x LOC_W | Location tag that falls off |

## Verification
The bench targets dual drops while the belt is full. A design with the wrong port priority swaps the two newest entries. A design with an off-by-one shift releases the wrong tag, or releases a tag when the back position was empty. It applies branches and drops in the same cycle, and duplicate or truncated congruence lists. A design that pushed drops before reordering would lose the new entries or pick stale ones. It issues relocations at dead belt numbers, which a careless design would write into a slot that later becomes live. It also runs stamps through several wraps of the counter, where a wrong width or a wrong order within a cycle shows up as mismatched timestamps.

// File: rtl/beltMapPkg.sv
package beltMapPkg;
  // Strobes from the control half to the mapping datapath
  typedef struct packed {
    logic doBranch;
    logic doReloc;
  } beltStrobeT;
endpackage

// File: rtl/beltCtrl.sv
module beltCtrl
  import beltMapPkg::*;
#(
  parameter int DROP_PORTS = 2,
  parameter int STAMP_W    = 4,
  parameter int PORT_W     = 1,
  parameter int DCNT_W     = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [DROP_PORTS-1:0]             dropValid,
  input  logic                              brTaken,
  input  logic                              relocValid,
  output beltStrobeT                        strobe,
  output logic [DCNT_W-1:0]                 dropCount,
  output logic [DROP_PORTS-1:0][PORT_W-1:0] slotPort,
  output logic [STAMP_W-1:0]                stampBase
);

  logic [STAMP_W-1:0] stampCtr;

  // Pack the active ports into front slots, lowest port first
  always_comb begin
    int cnt;
    cnt      = 0;
    slotPort = '0;
    for (int p = 0; p < DROP_PORTS; p++) begin
      if (dropValid[p]) begin
        slotPort[cnt[PORT_W-1:0]] = PORT_W'(p);
        cnt++;
      end
    end
    dropCount = DCNT_W'(cnt);
  end

  always_comb begin
    strobe.doBranch = brTaken;
    strobe.doReloc  = relocValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stampCtr <= '0;
    else       stampCtr <= stampCtr + STAMP_W'(dropCount);
  end

  assign stampBase = stampCtr;

  // R4
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> stampCtr == $past(stampCtr) + STAMP_W'($countones($past(dropValid))));

endmodule

// File: rtl/beltStore.sv
module beltStore
  import beltMapPkg::*;
#(
  parameter int BELT_SIZE  = 8,
  parameter int LOC_W      = 6,
  parameter int DROP_PORTS = 2,
  parameter int RD_PORTS   = 2,
  parameter int POS_W      = 3,
  parameter int CNT_W      = 4,
  parameter int STAMP_W    = 4,
  parameter int PORT_W     = 1,
  parameter int DCNT_W     = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  beltStrobeT                         strobe,
  input  logic [DCNT_W-1:0]                  dropCount,
  input  logic [DROP_PORTS-1:0][PORT_W-1:0]  slotPort,
  input  logic [STAMP_W-1:0]                 stampBase,
  input  logic [DROP_PORTS-1:0][LOC_W-1:0]   dropLoc,
  input  logic [CNT_W-1:0]                   brCount,
  input  logic [BELT_SIZE-1:0][POS_W-1:0]    brList,
  input  logic [POS_W-1:0]                   relocPos,
  input  logic [LOC_W-1:0]                   relocLoc,
  input  logic [RD_PORTS-1:0][POS_W-1:0]     rdPos,
  output logic [RD_PORTS-1:0]                rdValid,
  output logic [RD_PORTS-1:0][LOC_W-1:0]     rdLoc,
  output logic [RD_PORTS-1:0][STAMP_W-1:0]   rdStamp,
  output logic [DROP_PORTS-1:0]              relValid,
  output logic [DROP_PORTS-1:0][LOC_W-1:0]   relLoc
);

  typedef struct packed {
    logic [LOC_W-1:0]   loc;
    logic [STAMP_W-1:0] stamp;
  } entryT;

  entryT            slots_q [BELT_SIZE];
  entryT            relocd  [BELT_SIZE];
  entryT            reordd  [BELT_SIZE];
  entryT            slotsNext [BELT_SIZE];
  entryT            dropEnt [DROP_PORTS];
  logic [CNT_W-1:0] count_q, count1, countNext;

  // Stage 0: relocation against the current belt
  always_comb begin
    for (int p = 0; p < BELT_SIZE; p++) relocd[p] = slots_q[p];
    if (strobe.doReloc && int'(relocPos) < int'(count_q))
      relocd[relocPos].loc = relocLoc;
  end

  // Stage 1: congruence reorder
  always_comb begin
    for (int p = 0; p < BELT_SIZE; p++) reordd[p] = relocd[p];
    count1 = count_q;
    if (strobe.doBranch) begin
      for (int p = 0; p < BELT_SIZE; p++) reordd[p] = relocd[brList[p]];
      count1 = (int'(brCount) > BELT_SIZE) ? CNT_W'(BELT_SIZE) : brCount;
    end
  end

  // Stage 2: new drops, stamped oldest-first from the highest port
  always_comb begin
    for (int j = 0; j < DROP_PORTS; j++) begin
      dropEnt[j].loc   = dropLoc[slotPort[j]];
      dropEnt[j].stamp = stampBase + STAMP_W'(int'(dropCount) - 1 - j);
    end
  end

  generate
    for (genvar p = 0; p < BELT_SIZE; p++) begin : g_shift
      always_comb begin
        slotsNext[p] = reordd[p];
        for (int s = 1; s <= DROP_PORTS; s++) begin
          if (int'(dropCount) == s) begin
            if (p < s) slotsNext[p] = dropEnt[p % DROP_PORTS];
            else       slotsNext[p] = reordd[(p - s + BELT_SIZE) % BELT_SIZE];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    int c;
    c = int'(count1) + int'(dropCount);
    if (c > BELT_SIZE) c = BELT_SIZE;
    countNext = CNT_W'(c);
  end

  // Entries pushed off the back
  generate
    for (genvar k = 0; k < DROP_PORTS; k++) begin : g_rel
      assign relValid[k] = (k < int'(dropCount)) && ((BELT_SIZE - 1 - k) < int'(count1));
      assign relLoc[k]   = relValid[k] ? reordd[BELT_SIZE-1-k].loc : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count_q <= '0;
      for (int p = 0; p < BELT_SIZE; p++) slots_q[p] <= '0;
    end else begin
      count_q <= countNext;
      for (int p = 0; p < BELT_SIZE; p++) slots_q[p] <= slotsNext[p];
    end
  end

  generate
    for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
      assign rdValid[r] = int'(rdPos[r]) < int'(count_q);
      assign rdLoc[r]   = rdValid[r] ? slots_q[rdPos[r]].loc   : '0;
      assign rdStamp[r] = rdValid[r] ? slots_q[rdPos[r]].stamp : '0;
    end
  endgenerate

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(count_q) <= BELT_SIZE);

  // R5
  release_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    relValid[0] |=> int'(count_q) == BELT_SIZE);

  // R2
  front_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(dropCount) == 1 && !strobe.doBranch) |=> slots_q[0].loc == $past(dropLoc[slotPort[0]]));

  // R7
  branch_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doBranch && dropCount == '0 && int'(brCount) <= BELT_SIZE) |=> count_q == $past(brCount));

  // R9
  reloc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doReloc && !strobe.doBranch && dropCount == '0) |=> count_q == $past(count_q));

endmodule

// File: rtl/beltMap.sv
module beltMap
  import beltMapPkg::*;
#(
  parameter int BELT_SIZE  = 8,
  parameter int LOC_W      = 6,
  parameter int DROP_PORTS = 2,
  parameter int RD_PORTS   = 2,
  localparam int POS_W     = $clog2(BELT_SIZE),
  localparam int CNT_W     = POS_W + 1,
  localparam int STAMP_W   = POS_W + 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [DROP_PORTS-1:0]              dropValid,
  input  logic [DROP_PORTS-1:0][LOC_W-1:0]   dropLoc,
  input  logic                               brTaken,
  input  logic [CNT_W-1:0]                   brCount,
  input  logic [BELT_SIZE-1:0][POS_W-1:0]    brList,
  input  logic                               relocValid,
  input  logic [POS_W-1:0]                   relocPos,
  input  logic [LOC_W-1:0]                   relocLoc,
  input  logic [RD_PORTS-1:0][POS_W-1:0]     rdPos,
  output logic [RD_PORTS-1:0]                rdValid,
  output logic [RD_PORTS-1:0][LOC_W-1:0]     rdLoc,
  output logic [RD_PORTS-1:0][STAMP_W-1:0]   rdStamp,
  output logic [DROP_PORTS-1:0]              relValid,
  output logic [DROP_PORTS-1:0][LOC_W-1:0]   relLoc
);

  localparam int PORT_W = (DROP_PORTS > 1) ? $clog2(DROP_PORTS) : 1;
  localparam int DCNT_W = $clog2(DROP_PORTS + 1);

  beltStrobeT                        strobe;
  logic [DCNT_W-1:0]                 dropCount;
  logic [DROP_PORTS-1:0][PORT_W-1:0] slotPort;
  logic [STAMP_W-1:0]                stampBase;

  beltCtrl #(
    .DROP_PORTS(DROP_PORTS), .STAMP_W(STAMP_W), .PORT_W(PORT_W), .DCNT_W(DCNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .dropValid(dropValid), .brTaken(brTaken),
    .relocValid(relocValid), .strobe(strobe), .dropCount(dropCount),
    .slotPort(slotPort), .stampBase(stampBase)
  );

  beltStore #(
    .BELT_SIZE(BELT_SIZE), .LOC_W(LOC_W), .DROP_PORTS(DROP_PORTS), .RD_PORTS(RD_PORTS),
    .POS_W(POS_W), .CNT_W(CNT_W), .STAMP_W(STAMP_W), .PORT_W(PORT_W), .DCNT_W(DCNT_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dropCount(dropCount), .slotPort(slotPort),
    .stampBase(stampBase), .dropLoc(dropLoc), .brCount(brCount), .brList(brList),
    .relocPos(relocPos), .relocLoc(relocLoc), .rdPos(rdPos), .rdValid(rdValid),
    .rdLoc(rdLoc), .rdStamp(rdStamp), .relValid(relValid), .relLoc(relLoc)
  );

endmodule

// File: tb/beltMap_bench.sv
module beltMap_bench;
  localparam int N       = 8;
  localparam int LOC_W   = 6;
  localparam int P       = 2;
  localparam int RD      = 2;
  localparam int POS_W   = 3;
  localparam int CNT_W   = 4;
  localparam int STAMP_W = 4;
  localparam int SMOD    = 2 * N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [P-1:0]              dropValid;
  logic [P-1:0][LOC_W-1:0]   dropLoc;
  logic                      brTaken;
  logic [CNT_W-1:0]          brCount;
  logic [N-1:0][POS_W-1:0]   brList;
  logic                      relocValid;
  logic [POS_W-1:0]          relocPos;
  logic [LOC_W-1:0]          relocLoc;
  logic [RD-1:0][POS_W-1:0]  rdPos;
  logic [RD-1:0]             rdValid;
  logic [RD-1:0][LOC_W-1:0]  rdLoc;
  logic [RD-1:0][STAMP_W-1:0] rdStamp;
  logic [P-1:0]              relValid;
  logic [P-1:0][LOC_W-1:0]   relLoc;

  beltMap #(.BELT_SIZE(N), .LOC_W(LOC_W), .DROP_PORTS(P), .RD_PORTS(RD)) u_beltMap (
    .clk(clk), .rstN(rstN), .dropValid(dropValid), .dropLoc(dropLoc), .brTaken(brTaken),
    .brCount(brCount), .brList(brList), .relocValid(relocValid), .relocPos(relocPos),
    .relocLoc(relocLoc), .rdPos(rdPos), .rdValid(rdValid), .rdLoc(rdLoc),
    .rdStamp(rdStamp), .relValid(relValid), .relLoc(relLoc)
  );

  always #2 clk = ~clk;

  typedef struct { int loc; int stamp; } entT;
  entT q[$];
  int  stampCtr = 0;
  int  nChecks = 0;
  int  nFails  = 0;
  int  cyc     = 0;
  bit  finished = 0;

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic idle();
    dropValid = '0; dropLoc = '0; brTaken = 0; brCount = '0; brList = '0;
    relocValid = 0; relocPos = '0; relocLoc = '0;
  endtask

  task automatic checkReads(string req);
    for (int r = 0; r < RD; r++) begin
      int pos = int'(rdPos[r]);
      if (pos < q.size()) begin
        check(req, "rdValid", int'(rdValid[r]), 1);
        check(req, "rdLoc", int'(rdLoc[r]), q[pos].loc);
        check("R4", "rdStamp", int'(rdStamp[r]), q[pos].stamp);
      end else begin
        check("R6", "rdValid", int'(rdValid[r]), 0);
        check("R6", "rdLoc", int'(rdLoc[r]), 0);
        check("R6", "rdStamp", int'(rdStamp[r]), 0);
      end
    end
  endtask

  // Called at a negative edge with inputs set; compares, clocks, updates model
  task automatic runCycle(string req);
    entT s0[$];
    entT s1[$];
    entT nq[$];
    int  act[$];
    int  d;
    rdPos[0] = POS_W'(cyc % N);
    rdPos[1] = POS_W'((cyc * 3 + 1) % N);
    s0 = q;
    if (relocValid && int'(relocPos) < s0.size()) s0[relocPos].loc = int'(relocLoc);
    if (brTaken) begin
      for (int i = 0; i < int'(brCount); i++) s1.push_back(s0[brList[i]]);
    end else s1 = s0;
    for (int p = 0; p < P; p++) if (dropValid[p]) act.push_back(p);
    d = act.size();
    #1;
    checkReads(req);
    for (int k = 0; k < P; k++) begin
      bit ev = (k < d) && ((N - 1 - k) < s1.size());
      check("R5", "relValid", int'(relValid[k]), int'(ev));
      check("R5", "relLoc", int'(relLoc[k]), ev ? s1[N-1-k].loc : 0);
    end
    for (int j = 0; j < d; j++) begin
      entT e;
      e.loc   = int'(dropLoc[act[j]]);
      e.stamp = (stampCtr + d - 1 - j) % SMOD;
      nq.push_back(e);
    end
    foreach (s1[i]) nq.push_back(s1[i]);
    while (nq.size() > N) void'(nq.pop_back());
    @(posedge clk);
    q = nq;
    stampCtr = (stampCtr + d) % SMOD;
    cyc++;
    @(negedge clk);
  endtask

  task automatic randomInputs();
    idle();
    dropValid = P'($urandom_range(0, (1 << P) - 1));
    for (int p = 0; p < P; p++) dropLoc[p] = LOC_W'($urandom);
    if ($urandom_range(0, 7) == 0 && q.size() > 0) begin
      brTaken = 1;
      brCount = CNT_W'($urandom_range(0, N));
      for (int i = 0; i < N; i++) brList[i] = POS_W'($urandom_range(0, q.size() - 1));
    end
    if ($urandom_range(0, 3) == 0) begin
      relocValid = 1;
      relocPos   = POS_W'($urandom_range(0, N - 1));
      relocLoc   = LOC_W'($urandom);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle();
    rdPos = '0;
    repeat (3) @(negedge clk);
    // R1: empty after reset
    rdPos[0] = 0; rdPos[1] = 5;
    #1;
    for (int r = 0; r < RD; r++) begin
      check("R1", "rdValid", int'(rdValid[r]), 0);
      check("R1", "rdLoc", int'(rdLoc[r]), 0);
    end
    @(negedge clk);
    rstN = 1;
    runCycle("R1");

    // R2: single drops from port 1 then port 0
    dropValid = 2'b10; dropLoc[1] = 6'd11; runCycle("R2");
    idle(); dropValid = 2'b01; dropLoc[0] = 6'd12; runCycle("R2");
    idle(); repeat (4) runCycle("R2");

    // R3: both ports in one cycle, port 0 lands at the front
    dropValid = 2'b11; dropLoc[0] = 6'd21; dropLoc[1] = 6'd22; runCycle("R3");
    idle(); repeat (8) runCycle("R3");

    // R5: overfill with double drops
    for (int i = 0; i < 6; i++) begin
      dropValid = 2'b11; dropLoc[0] = LOC_W'(30 + 2 * i); dropLoc[1] = LOC_W'(31 + 2 * i);
      runCycle("R5");
    end
    idle(); repeat (8) runCycle("R5");

    // R7: reorder with duplicates and truncation
    brTaken = 1; brCount = 4'd3; brList = '0;
    brList[0] = 3'd5; brList[1] = 3'd0; brList[2] = 3'd5;
    runCycle("R7");
    idle(); repeat (8) runCycle("R7");

    // R9: relocation of a live entry, then of a dead belt number
    relocValid = 1; relocPos = 3'd1; relocLoc = 6'd50; runCycle("R9");
    idle(); relocValid = 1; relocPos = 3'd6; relocLoc = 6'd51; runCycle("R9");
    idle(); repeat (8) runCycle("R9");

    // R8: branch plus drops in one cycle
    brTaken = 1; brCount = 4'd2; brList = '0; brList[0] = 3'd2; brList[1] = 3'd0;
    dropValid = 2'b11; dropLoc[0] = 6'd60; dropLoc[1] = 6'd61;
    relocValid = 1; relocPos = 3'd2; relocLoc = 6'd62;
    runCycle("R8");
    idle(); repeat (8) runCycle("R8");

    // Mixed random traffic; stamps wrap many times (R4)
    for (int i = 0; i < 4000; i++) begin
      randomInputs();
      runCycle("R2");
    end
    idle(); repeat (8) runCycle("R4");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule